// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit turns 32-bit virtual addresses from a simple processor into physical addresses using 4096-byte pages. The upper 20 address bits select a page, and the lower 12 bits pass through unchanged as the byte offset. A page-map base register input gives the physical location of a single-level table that holds one 32-bit word per page. When that register is zero, translation is switched off and every address comes out exactly as it went in.

Recent translations are kept in a four-entry, fully associative buffer. A hit answers in the next cycle. A miss starts one read of the page-map word over a request/response memory port and holds `busy` until the word returns. Every access carries a type (read, write or execute), and that type is checked against the permission flags of the page. An access that is not allowed, or that touches an unmapped page, is refused with a fault code. A faulting lookup is never cached. A `flush` pulse clears the buffer and must be given whenever the base register changes.

Top module: `addr_xlate_top`

## Requirements
- R1: A successful translation returns `{frame, offset}`. The frame is the 20-bit field [31:12] of the page-map word, and the offset is the request's bits [11:0] unchanged.
- R2: A miss issues exactly one single-cycle `mem_req`, with `mem_addr` = (`pm_base` with bits [1:0] forced to zero) + page number × 4.
- R3: When `pm_base` is zero, the response comes in the cycle after the request, with `rsp_paddr` equal to `req_vaddr`, fault code 0, and no memory read.
- R4: Page-map word layout: bit 0 = mapped, bit 1 = read allowed, bit 2 = write allowed, bit 3 = execute allowed. Bits [11:4] are reserved and must be zero.
- R5: A word with bit 0 clear, or with any reserved bit set, gives fault code 1 (page fault) and `rsp_paddr` 0, and nothing is cached.
- R6: The access type codes are 0 = read, 1 = write, 2 = execute, and 3 is allowed for no page. A type that the page does not permit gives fault code 2 (protection fault) and `rsp_paddr` 0, on a hit as well as after a walk, and a walk that ends this way caches nothing.
- R7: A buffer hit responds in the cycle after the request, with no memory read.
- R8: On a miss, `busy` is high from the cycle after the request until the cycle in which `mem_rvalid` is seen. The response appears, and `busy` drops, in the following cycle.
- R9: The buffer holds 4 translations. Each successful walk fills the slot named by a round-robin pointer, and the pointer then advances.
- R10: A `flush` pulse invalidates every buffered translation in one cycle, so the next access to any page misses.
- R11: A request presented while `busy` is high is ignored. It produces no response and no memory read.
- R12: While `rst_n` is low and after its release, `busy`, `rsp_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all buffered translations |
| pm_base | input | 32 | Page-map physical base; zero disables translation |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_type | input | 2 | Access type: 0 read, 1 write, 2 execute |
| busy | output | 1 | Walk in progress; requests ignored |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| mem_req | output | 1 | Page-map read request (one cycle) |
| mem_addr | output | 32 | Page-map word address |
| mem_rvalid | input | 1 | Page-map read data valid |
| mem_rdata | input | 32 | Page-map word |

## Verification
Twelve pages are swept with every access type. The page-map words are generated arithmetically so that they cover unmapped pages, pages with no permissions and every combination of permission flags. This sweep separates walk results from hit results, and protection faults from page faults. A second pass over the same pages, with more pages than buffer slots, reveals the round-robin eviction order through hit-or-miss latency and the memory request count. Further patterns cover a flush followed by a re-access, a request presented during a walk, the reserved type code, and a run of pass-through addresses with the base at zero. The pass-through run shows that no memory read takes place and that the address is returned untouched.

// File: rtl/xlate_pkg.sv
// Shared types and helpers for the address translation unit.
// Assumes a permission triple ordered {execute, write, read}.
package xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ISSUE = 2'd1,
        W_WAIT  = 2'd2
    } walk_state_e;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    // Decide whether a permission triple allows an access type.
    function automatic logic perm_allows(input logic [2:0] perm, input logic [1:0] typ);
        case (typ)
            ACC_READ:  perm_allows = perm[0];
            ACC_WRITE: perm_allows = perm[1];
            ACC_EXEC:  perm_allows = perm[2];
            default:   perm_allows = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/xlate_tlb.sv
// Fully associative translation buffer with round-robin fill.
// Assumes the owner never installs a page number that is already present,
// so at most one slot hits. Flush wins over a same-cycle install.
module xlate_tlb #(
    parameter int VPN_W = 20,
    parameter int NENT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [VPN_W-1:0] hit_ppn,
    output logic [2:0]       hit_perm,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [VPN_W-1:0] ins_ppn,
    input  logic [2:0]       ins_perm
);
    localparam int PTR_W = (NENT > 1) ? $clog2(NENT) : 1;

    logic [NENT-1:0]  vld_q;
    logic [VPN_W-1:0] tag_q  [NENT];
    logic [VPN_W-1:0] ppn_q  [NENT];
    logic [2:0]       perm_q [NENT];
    logic [PTR_W-1:0] ptr_q;
    logic [NENT-1:0]  hit_vec;

    // Per-slot tag compare.
    for (genvar g = 0; g < NENT; g++) begin : g_cmp
        assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_vpn);
    end

    // Merge the hitting slot's payload onto the outputs.
    always_comb begin
        hit_ppn  = '0;
        hit_perm = '0;
        for (int i = 0; i < NENT; i++) begin
            if (hit_vec[i]) begin
                hit_ppn  = hit_ppn | ppn_q[i];
                hit_perm = hit_perm | perm_q[i];
            end
        end
    end
    assign hit = |hit_vec;

    // Slot storage: clear on reset or flush, fill the pointed slot on install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else if (ins_en) begin
            for (int i = 0; i < NENT; i++) begin
                if (ptr_q == PTR_W'(i)) begin
                    vld_q[i]  <= 1'b1;
                    tag_q[i]  <= ins_vpn;
                    ppn_q[i]  <= ins_ppn;
                    perm_q[i] <= ins_perm;
                end
            end
            ptr_q <= (ptr_q == PTR_W'(NENT - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // R9: no two slots may ever match the same page number.
    p_unique_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R10: a flush leaves no valid slot behind.
    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0));

endmodule

// File: rtl/xlate_walker.sv
// Single-level page-map reader: issues one word read per miss and waits.
// Assumes an aligned base and that memory answers every request exactly once.
module xlate_walker #(
    parameter int VA_W  = 32,
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VPN_W-1:0] start_vpn,
    input  logic [VA_W-1:0]  base,
    output logic             busy,
    output logic             done,
    output logic [VPN_W-1:0] cur_vpn,
    output logic             mem_req,
    output logic [VA_W-1:0]  mem_addr,
    input  logic             mem_rvalid
);
    import xlate_pkg::*;

    localparam int PAD_W = VA_W - VPN_W - 2;

    walk_state_e      state_q;
    logic [VPN_W-1:0] vpn_q;

    // Walk sequencing: idle -> issue one read -> wait for data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            vpn_q   <= '0;
        end else begin
            case (state_q)
                W_IDLE:  if (start) begin
                             state_q <= W_ISSUE;
                             vpn_q   <= start_vpn;
                         end
                W_ISSUE: state_q <= W_WAIT;
                W_WAIT:  if (mem_rvalid) state_q <= W_IDLE;
                default: state_q <= W_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != W_IDLE);
    assign mem_req  = (state_q == W_ISSUE);
    assign done     = (state_q == W_WAIT) && mem_rvalid;
    assign cur_vpn  = vpn_q;
    assign mem_addr = base + {{PAD_W{1'b0}}, vpn_q, 2'b00};

    // R2: the page-map read is a single-cycle pulse.
    p_mem_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R8: memory is only asked while the unit reports busy.
    p_req_in_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

// File: rtl/addr_xlate_top.sv
// Paged address translation unit: pass-through when the base is zero,
// buffered lookup on hit, single-level page-map walk on miss, and
// per-access permission checks. Assumes pm_base is stable during a walk
// and that flush is pulsed after every base change.
module addr_xlate_top #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int NENT  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [VA_W-1:0] pm_base,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [1:0]      req_type,
    output logic            busy,
    output logic            rsp_valid,
    output logic [VA_W-1:0] rsp_paddr,
    output logic [1:0]      rsp_fault,
    output logic            mem_req,
    output logic [VA_W-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [VA_W-1:0] mem_rdata
);
    import xlate_pkg::*;

    localparam int VPN_W = VA_W - OFF_W;

    logic             walk_busy, walk_done, accept, xlate_off, walk_start;
    logic             tlb_hit, pte_ok, install;
    logic [VPN_W-1:0] req_vpn, tlb_ppn, walk_vpn, pte_ppn;
    logic [2:0]       tlb_perm, pte_perm;
    logic [VA_W-1:0]  base_al;
    logic [1:0]       typ_q;
    logic [OFF_W-1:0] off_q;

    assign busy       = walk_busy;
    assign accept     = req_valid && !walk_busy;
    assign xlate_off  = (pm_base == '0);
    assign base_al    = {pm_base[VA_W-1:2], 2'b00};
    assign req_vpn    = req_vaddr[VA_W-1:OFF_W];
    assign walk_start = accept && !xlate_off && !tlb_hit;

    // Page-map word decode.
    assign pte_ppn  = mem_rdata[VA_W-1:OFF_W];
    assign pte_perm = mem_rdata[3:1];
    assign pte_ok   = mem_rdata[0] && (mem_rdata[OFF_W-1:4] == '0);
    assign install  = walk_done && pte_ok && perm_allows(pte_perm, typ_q);

    xlate_tlb #(.VPN_W(VPN_W), .NENT(NENT)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_vpn   (req_vpn),
        .hit      (tlb_hit),
        .hit_ppn  (tlb_ppn),
        .hit_perm (tlb_perm),
        .ins_en   (install),
        .ins_vpn  (walk_vpn),
        .ins_ppn  (pte_ppn),
        .ins_perm (pte_perm)
    );

    xlate_walker #(.VA_W(VA_W), .VPN_W(VPN_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (walk_start),
        .start_vpn  (req_vpn),
        .base       (base_al),
        .busy       (walk_busy),
        .done       (walk_done),
        .cur_vpn    (walk_vpn),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid)
    );

    // Hold the access type and offset of the request being walked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            typ_q <= '0;
            off_q <= '0;
        end else if (walk_start) begin
            typ_q <= req_type;
            off_q <= req_vaddr[OFF_W-1:0];
        end
    end

    // Response register: pass-through, hit result, or end-of-walk result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= FLT_NONE;
        end else begin
            rsp_valid <= 1'b0;
            if (accept && xlate_off) begin
                rsp_valid <= 1'b1;
                rsp_paddr <= req_vaddr;
                rsp_fault <= FLT_NONE;
            end else if (accept && tlb_hit) begin
                rsp_valid <= 1'b1;
                if (perm_allows(tlb_perm, req_type)) begin
                    rsp_paddr <= {tlb_ppn, req_vaddr[OFF_W-1:0]};
                    rsp_fault <= FLT_NONE;
                end else begin
                    rsp_paddr <= '0;
                    rsp_fault <= FLT_PROT;
                end
            end else if (walk_done) begin
                rsp_valid <= 1'b1;
                if (!pte_ok) begin
                    rsp_paddr <= '0;
                    rsp_fault <= FLT_PAGE;
                end else if (!perm_allows(pte_perm, typ_q)) begin
                    rsp_paddr <= '0;
                    rsp_fault <= FLT_PROT;
                end else begin
                    rsp_paddr <= {pte_ppn, off_q};
                    rsp_fault <= FLT_NONE;
                end
            end
        end
    end

    // R3: pass-through answers next cycle with the address untouched.
    p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && xlate_off) |=> (rsp_valid && rsp_fault == FLT_NONE
                                   && rsp_paddr == $past(req_vaddr)));

    // R7: a hit answers next cycle without entering a walk.
    p_hit_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !xlate_off && tlb_hit) |=> (rsp_valid && !busy));

    // R8: a miss raises busy and withholds the response.
    p_miss_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start |=> (busy && !rsp_valid));

    // R5/R6: only fault-free walks are cached.
    p_install_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        install |=> (rsp_valid && rsp_fault == FLT_NONE));

    // R12: nothing is reported while reset is held.
    p_reset_quiet_r12: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !busy));

endmodule

// File: tb/tb_addr_xlate_top.sv
// Self-checking bench: swept accesses against an arithmetic page map,
// with a small reference model of buffer residency.
module tb_addr_xlate_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] pm_base = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_type = '0;
    logic        busy, rsp_valid, mem_req;
    logic [31:0] rsp_paddr, mem_addr;
    logic [1:0]  rsp_fault;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int vecs = 0;
    int errs = 0;
    int mem_cnt = 0;
    int mem_lat = 1;
    int pend = 0;
    bit finished = 0;
    logic [31:0] last_maddr = '0;
    logic [31:0] base_al = '0;

    logic [19:0] m_tag [4];
    bit          m_vld [4];
    int          m_ptr = 0;

    always #2 clk = ~clk;

    addr_xlate_top dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pm_base(pm_base),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_type(req_type),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Arithmetic page map: mix of unmapped pages and permission sets (R4 layout).
    function automatic logic [31:0] pte_of(input logic [19:0] vpn);
        logic [19:0] frame;
        logic [2:0]  rwx;
        logic        v;
        frame = vpn * 20'd37 + 20'h00400;
        rwx   = 3'((vpn * 3 + 1) & 7);
        v     = ((vpn % 7) != 3);
        return {frame, 8'h00, rwx, v};
    endfunction

    function automatic bit allows(input logic [31:0] pte, input logic [1:0] t);
        if (t == 2'd0) return pte[1];
        if (t == 2'd1) return pte[2];
        if (t == 2'd2) return pte[3];
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Memory responder for page-map reads.
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = pte_of(20'((last_maddr - base_al) >> 2));
            end
        end else if (mem_req) begin
            mem_cnt++;
            last_maddr = mem_addr;
            pend = mem_lat;
        end
    end

    // One request with full checking; optionally pokes a second request mid-walk.
    task automatic do_req(input logic [31:0] va, input logic [1:0] t, input bit intrude);
        logic [19:0] vpn;
        logic [31:0] pte, exp_pa;
        logic [1:0]  exp_f;
        bit pass, exp_hit, bsy1;
        int slot, cyc, mc0;
        vpn  = va[31:12];
        pte  = pte_of(vpn);
        pass = (pm_base == 0);
        slot = -1;
        for (int i = 0; i < 4; i++) if (m_vld[i] && m_tag[i] == vpn) slot = i;
        exp_hit = pass || (slot >= 0);
        if (pass) begin
            exp_f = 2'd0; exp_pa = va;
        end else if (!pte[0]) begin
            exp_f = 2'd1; exp_pa = '0;
        end else if (!allows(pte, t)) begin
            exp_f = 2'd2; exp_pa = '0;
        end else begin
            exp_f = 2'd0; exp_pa = {pte[31:12], va[11:0]};
        end
        mc0 = mem_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_type = t;
        @(negedge clk);
        req_valid = 1'b0;
        cyc  = 1;
        bsy1 = busy;
        if (intrude && !exp_hit) begin
            req_valid = 1'b1; req_vaddr = va ^ 32'h0070_0000; req_type = 2'd0;
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
        end
        while (!rsp_valid && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        chk(rsp_valid, "R8 response arrives", 32'(rsp_valid), 32'd1);
        chk(rsp_fault == exp_f, exp_f == 2'd1 ? "R5 fault code" : "R6 fault code", 32'(rsp_fault), 32'(exp_f));
        chk(rsp_paddr == exp_pa, pass ? "R3 pass-through address" : "R1 physical address", rsp_paddr, exp_pa);
        if (exp_hit) begin
            chk(cyc == 1, pass ? "R3 latency" : "R7 hit latency", 32'(cyc), 32'd1);
            chk(mem_cnt == mc0, pass ? "R3 no memory read" : "R7 no memory read", 32'(mem_cnt - mc0), 32'd0);
        end else begin
            chk(bsy1 && !busy, "R8 busy window", {30'd0, bsy1, busy}, 32'd2);
            chk(mem_cnt == mc0 + 1, "R2 one read per miss", 32'(mem_cnt - mc0), 32'd1);
            chk(last_maddr == base_al + {10'd0, vpn, 2'b00}, "R2 entry address", last_maddr, base_al + {10'd0, vpn, 2'b00});
            if (exp_f == 2'd0) begin
                m_tag[m_ptr] = vpn; m_vld[m_ptr] = 1; m_ptr = (m_ptr + 1) % 4;
            end
        end
        if (intrude) begin
            mc0 = mem_cnt;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk(!rsp_valid, "R11 no extra response", 32'(rsp_valid), 32'd0);
            end
            chk(mem_cnt == mc0, "R11 no extra read", 32'(mem_cnt - mc0), 32'd0);
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        for (int i = 0; i < 4; i++) m_vld[i] = 0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        chk(!busy && !rsp_valid && !mem_req, "R12 outputs in reset", {29'd0, busy, rsp_valid, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rsp_valid && !mem_req, "R12 outputs after reset", {29'd0, busy, rsp_valid, mem_req}, 32'd0);

        pm_base = 32'h0004_0003;
        base_al = 32'h0004_0000;
        do_flush();
        // Sweep pages x access types (R1, R2, R5, R6, R7, R8, R9).
        for (int v = 0; v < 12; v++) begin
            for (int t = 0; t < 3; t++) begin
                mem_lat = v % 3 + 1;
                do_req({20'(v), 12'((v * 331 + t * 77) % 4096)}, 2'(t), 1'b0);
            end
        end
        // Second pass: eviction order shows through hit/miss (R9).
        for (int v = 11; v >= 0; v--) begin
            mem_lat = 2;
            do_req({20'(v), 12'(v * 5)}, 2'd0, 1'b0);
        end
        // Reserved type code on a resident page (R6).
        do_req({20'd0, 12'h123}, 2'd3, 1'b0);
        // Flush then re-access a resident page (R10).
        do_req({20'd1, 12'h010}, 2'd2, 1'b0);
        do_flush();
        do_req({20'd1, 12'h020}, 2'd2, 1'b0);
        // Request presented during a walk (R11).
        mem_lat = 3;
        do_req({20'd7, 12'h0AB}, 2'd0, 1'b1);
        // Pass-through with base at zero (R3).
        pm_base = '0;
        do_flush();
        for (int k = 0; k < 16; k++) begin
            do_req(32'(k) * 32'h1357_9BDF + 32'h0000_0F0F, 2'(k % 4), 1'b0);
        end
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vecs++; errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule